// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of a configurable width W (16 by default). It returns the full 2W-bit product after W clock cycles. It uses one W-bit adder. It keeps the multiplicand, a multiplier that shifts right, and a 2W-bit product register. On every iteration the low bit of the multiplier decides whether the multiplicand is added into the upper half of the product. The product register then moves right by one place, and the carry of that addition enters at the top.

Each operand pair is offered by pulsing `start` with the operands present. The block accepts the pair only while `busy` is low, so `!busy` acts as the ready signal for the input side. A `start` that arrives while `busy` is high is dropped, with no effect on the operation in progress. The caller must hold the operands until it sees `busy` rise, or offer them again later. The output side has no back-pressure. `done` is a level that stays high, and `product` stays stable, until the next start is accepted, so the consumer can read the result at any time.

Top module: `seq_mul`

## Requirements
- R1: After reset `busy` is 0, `done` is 0 and `product` is 0.
- R2: A start sampled while `busy` is 0 loads the operands. On the next cycle `busy` is 1 and `done` is 0.
- R3: The finished `product` equals multiplicand × multiplier as unsigned integers, over all 2W bits (for example, with W = 4, 1101 × 1011 gives 10001111).
- R4: `done` rises, and `busy` falls, exactly W clock cycles after the edge that accepted the start. `busy` and `done` are never both high.
- R5: After completion, `done` stays 1 and `product` keeps its value until the next accepted start, whatever the operand inputs do.
- R6: A start sampled while `busy` is 1 is ignored. It changes neither the result nor the completion time.
- R7: The carry out of each addition into the upper half is kept, so all-ones operands give the exact product (2^W − 1)².
- R8: A multiplier bit of 0 causes a shift with no addition, so a zero operand gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin; accepted only while busy is low |
| multiplicand | input | W | Unsigned first operand, sampled on acceptance |
| multiplier | input | W | Unsigned second operand, sampled on acceptance |
| busy | output | 1 | An operation is in progress (the inverse is input ready) |
| done | output | 1 | The result is valid; held until the next accepted start |
| product | output | 2W | Unsigned product |

## Verification
The bench builds two copies of the block: one at the default width of 16 and one at a width of 4. The narrow copy makes an exhaustive sweep of all 256 operand pairs practical, which covers every carry and shift pattern, including 1101 × 1011. The 16-bit copy checks all-ones, zero and one operands plus random pairs. On that copy, starts are poked in the middle of a run and the operands are changed while the result is held.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  mul_state_e    state;
  logic [CW-1:0] cnt;

  assign busy = (state == MUL_RUN);
  assign load = start && (state == MUL_IDLE);
  assign step = (state == MUL_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MUL_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        MUL_IDLE: begin
          if (start) begin
            state <= MUL_RUN;
            cnt   <= '0;
            done  <= 1'b0;
          end
        end
        MUL_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state <= MUL_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= MUL_IDLE;
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cnt == FULL));

  // R6
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt != '0));
endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0] mcand;
  logic [W-1:0] mplier;
  logic [W:0]   addend;
  logic [W:0]   sum;

  assign addend = mplier[0] ? {1'b0, mcand} : '0;
  assign sum    = {1'b0, prod[PW-1:W]} + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      mplier <= '0;
      prod   <= '0;
    end else if (load) begin
      mcand  <= a_in;
      mplier <= b_in;
      prod   <= '0;
    end else if (step) begin
      prod   <= {sum, prod[W-1:1]};
      mplier <= mplier >> 1;
    end
  end
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic load;
  logic step;

  seq_mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  seq_mul_dp #(.W(W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a_in  (multiplicand),
    .b_in  (multiplier),
    .prod  (product)
  );

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product)));
endmodule

// File: tb/seq_mul_test.sv
module seq_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start16 = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic        busy16, done16;
  logic [31:0] prod16;

  logic        start4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy4, done4;
  logic [7:0]  prod4;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  seq_mul #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start16), .multiplicand(a16),
    .multiplier(b16), .busy(busy16), .done(done16), .product(prod16));

  seq_mul #(.W(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .start(start4), .multiplicand(a4),
    .multiplier(b4), .busy(busy4), .done(done4), .product(prod4));

  function automatic logic [31:0] ref16(input logic [15:0] x, input logic [15:0] y);
    return 32'(x) * 32'(y);
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
    return 8'(x) * 8'(y);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input bit poke,
                       input string req);
    int lat;
    logic [31:0] exp;
    exp = ref16(x, y);
    @(negedge clk); start16 = 1'b1; a16 = x; b16 = y;
    @(negedge clk); start16 = 1'b0; a16 = 16'($urandom); b16 = 16'($urandom);
    check(busy16 === 1'b1 && done16 === 1'b0, "R2", {busy16, done16}, 2'b10);
    lat = 0;
    while (done16 !== 1'b1 && lat < 40) begin
      start16 = (poke && lat == 3);
      @(negedge clk);
      lat++;
    end
    start16 = 1'b0;
    check(lat == 16, poke ? "R6 latency" : "R4", lat, 16);
    check(busy16 === 1'b0, "R4 busy", busy16, 0);
    check(prod16 === exp, req, prod16, exp);
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y, input string req);
    int lat;
    logic [7:0] exp;
    exp = ref4(x, y);
    @(negedge clk); start4 = 1'b1; a4 = x; b4 = y;
    @(negedge clk); start4 = 1'b0; a4 = ~x; b4 = ~y;
    lat = 0;
    while (done4 !== 1'b1 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 4 && busy4 === 1'b0, "R4 narrow", lat, 4);
    check(prod4 === exp, req, prod4, exp);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1
    check(busy16 === 0 && done16 === 0 && prod16 === 0, "R1", {busy16, done16, prod16}, 0);
    check(busy4 === 0 && done4 === 0 && prod4 === 0, "R1 narrow", {busy4, done4, prod4}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run4(4'b1101, 4'b1011, "R3 13x11");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run4(4'(i), 4'(j), (i == 0 || j == 0) ? "R8 narrow" : "R3 narrow sweep");

    run16(16'hFFFF, 16'hFFFF, 1'b0, "R7 all ones");
    run16(16'hFFFF, 16'h0001, 1'b0, "R3 times one");
    run16(16'h0000, 16'hBEEF, 1'b0, "R8 zero multiplicand");
    run16(16'hBEEF, 16'h0000, 1'b0, "R8 zero multiplier");
    run16(16'h8000, 16'h8000, 1'b0, "R7 top bits");
    run16(16'h1234, 16'h5678, 1'b1, "R6 poke result");

    begin
      logic [31:0] held;
      held = prod16;
      repeat (6) begin
        @(negedge clk); a16 = 16'($urandom); b16 = 16'($urandom);
      end
      check(done16 === 1'b1 && prod16 === held, "R5", prod16, held);
    end

    for (int k = 0; k < 300; k++)
      run16(16'($urandom), 16'($urandom), (k % 7) == 0, "R3 random");

    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule